// File: doc/BRIEF.md
# Hamming Sector Check Syndrome Decoder

This block judges one 512-byte sector of flash data from two 24-bit Hamming check words. One word is the code the read path computed over the sector it has just read. The other is the three check bytes held in the spare area. Byte 0 of each word carries bits 7:0, byte 1 carries bits 15:8 and byte 2 carries bits 23:16.

The two words are combined by XOR into a syndrome. The block counts the ones in the syndrome and sorts the sector into one of four outcomes. When a single data bit has flipped, it also gives the location of that bit: a 9-bit byte offset inside the sector, a 3-bit bit index inside that byte, and an 8-bit mask with one bit set. Software or a later stage XORs the mask into the addressed byte. This block does not compute the code over the data and does not write the repaired byte back to memory.

A caller presents both words together with a one-cycle start strobe. All results come from registers and appear one clock later with a one-cycle valid pulse. They then hold until the next start.

Top module: `hecc_sector_check`

## Requirements
- R1: While reset is high and after it falls, before any start, valid_o is 0, status_o is 00, and byte_addr_o, bit_pos_o and flip_mask_o are all zero.
- R2: valid_o is 1 in the cycle after each cycle in which start_i is 1, and 0 in every other cycle. Starts in consecutive cycles give consecutive valid cycles.
- R3: When the calculated code equals the stored code (syndrome of all zeros), status_o is 00 (clean).
- R4: When the syndrome has exactly 12 ones, status_o is 01 (corrected), whatever the positions of those ones.
- R5: When the syndrome is nonzero and has fewer than 23 ones, but not exactly 12, status_o is 10 (uncorrectable).
- R6: When the syndrome has 23 or 24 ones, status_o is 11 (code failure).
- R7: With status 01, bit_pos_o bits 0, 1 and 2 equal syndrome bits 1, 3 and 5 in that order.
- R8: With status 01, byte_addr_o bits 0 through 8 equal syndrome bits 7, 9, 11, 13, 15, 17, 19, 21 and 23 in that order.
- R9: With status 01, flip_mask_o has exactly one bit set, at index bit_pos_o. With any other status, flip_mask_o, byte_addr_o and bit_pos_o are all zero.
- R10: In a cycle that follows a cycle without start_i, status_o, byte_addr_o, bit_pos_o and flip_mask_o keep their previous values, whatever happens on the code inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe: evaluate the two codes |
| calc_code_i | input | 24 | Code computed over the sector just read |
| stored_code_i | input | 24 | Code read from the spare area |
| valid_o | output | 1 | One-cycle pulse, one clock after start_i |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 code failure |
| byte_addr_o | output | 9 | Offset of the bad byte within the sector |
| bit_pos_o | output | 3 | Index of the bad bit within that byte |
| flip_mask_o | output | 8 | One-hot correction mask for the bad byte |

## Verification
Equal code pairs check that a clean sector gives status 00 and zero location fields. Syndromes built from a true single-bit error are tried at the corners, byte 0 bit 0 and byte 511 bit 7, and at random positions. These check that the odd syndrome bits reach the right address and bit fields and that the mask follows the bit index. Syndromes of weight 1, 2, 11, 13 and 22 test the uncorrectable band on both sides of 12. An arbitrary 12-one pattern shows that the count alone decides the corrected status, and weights 23 and 24 test the code-failure threshold. Back-to-back starts and long idle gaps with changing inputs check the valid pulse and that results are held between starts.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    // Code width for one 512-byte sector
    localparam int HECC_CODE_W = 24;
    // Odd syndrome bits carry the error location
    localparam int HECC_LOC_W  = HECC_CODE_W / 2;
    localparam int HECC_BIT_W  = 3;
    localparam int HECC_ADDR_W = HECC_LOC_W - HECC_BIT_W;
    localparam int HECC_LANE_W = 1 << HECC_BIT_W;
    localparam int HECC_CNT_W  = $clog2(HECC_CODE_W + 1);

    typedef enum logic [1:0] {
        HS_CLEAN  = 2'b00,
        HS_FIXED  = 2'b01,
        HS_UNCORR = 2'b10,
        HS_FAIL   = 2'b11
    } hecc_status_e;

    typedef struct packed {
        hecc_status_e                 status;
        logic [HECC_ADDR_W-1:0]       byte_addr;
        logic [HECC_BIT_W-1:0]        bit_pos;
        logic [HECC_LANE_W-1:0]       flip_mask;
    } hecc_result_t;

    localparam hecc_result_t HECC_RESULT_RST = '{
        status:    HS_CLEAN,
        byte_addr: '0,
        bit_pos:   '0,
        flip_mask: '0
    };

endpackage

// File: rtl/hecc_syndrome.sv
module hecc_syndrome
    import hecc_pkg::*;
#(
    parameter int CODE_W = HECC_CODE_W,
    parameter int LOC_W  = CODE_W / 2,
    parameter int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output logic [LOC_W-1:0]  odd_o,
    output logic [CNT_W-1:0]  weight_o,
    output logic              zero_o
);

    logic [CODE_W-1:0] syn;

    assign syn = calc_i ^ stored_i;

    // Gather the odd-indexed bits into a packed location word
    for (genvar k = 0; k < LOC_W; k++) begin : g_odd
        assign odd_o[k] = syn[2*k+1];
    end

    always_comb begin
        weight_o = '0;
        for (int i = 0; i < CODE_W; i++) begin
            weight_o = weight_o + CNT_W'(syn[i]);
        end
    end

    assign zero_o = (syn == '0);

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int CODE_W = HECC_CODE_W,
    parameter int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic [CNT_W-1:0] weight_i,
    input  logic             zero_i,
    output hecc_status_e     status_o
);

    localparam logic [CNT_W-1:0] FIX_WEIGHT  = CNT_W'(CODE_W / 2);
    localparam logic [CNT_W-1:0] FAIL_WEIGHT = CNT_W'(CODE_W - 1);

    always_comb begin
        if (zero_i) begin
            status_o = HS_CLEAN;
        end else if (weight_i == FIX_WEIGHT) begin
            status_o = HS_FIXED;
        end else if (weight_i >= FAIL_WEIGHT) begin
            status_o = HS_FAIL;
        end else begin
            status_o = HS_UNCORR;
        end
    end

endmodule

// File: rtl/hecc_locate.sv
module hecc_locate
    import hecc_pkg::*;
#(
    parameter int LOC_W  = HECC_LOC_W,
    parameter int BIT_W  = HECC_BIT_W,
    parameter int ADDR_W = LOC_W - BIT_W,
    parameter int LANE_W = 1 << BIT_W
) (
    input  logic [LOC_W-1:0]  odd_i,
    input  logic              fix_i,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic [BIT_W-1:0]  bit_pos_o,
    output logic [LANE_W-1:0] mask_o
);

    // The low location bits select the bit in the byte; the rest select the byte
    assign bit_pos_o   = fix_i ? odd_i[BIT_W-1:0]     : '0;
    assign byte_addr_o = fix_i ? odd_i[LOC_W-1:BIT_W] : '0;

    for (genvar j = 0; j < LANE_W; j++) begin : g_lane
        assign mask_o[j] = fix_i && (odd_i[BIT_W-1:0] == BIT_W'(j));
    end

endmodule

// File: rtl/hecc_sector_check.sv
module hecc_sector_check
    import hecc_pkg::*;
#(
    parameter int CODE_W = HECC_CODE_W,
    parameter int ADDR_W = HECC_ADDR_W,
    parameter int BIT_W  = HECC_BIT_W,
    parameter int LANE_W = HECC_LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] calc_code_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic              valid_o,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic [BIT_W-1:0]  bit_pos_o,
    output logic [LANE_W-1:0] flip_mask_o
);

    localparam int LOC_W = CODE_W / 2;
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] FIX_WEIGHT  = CNT_W'(CODE_W / 2);
    localparam logic [CNT_W-1:0] FAIL_WEIGHT = CNT_W'(CODE_W - 1);

    logic [LOC_W-1:0]  odd_bits;
    logic [CNT_W-1:0]  weight;
    logic              syn_zero;
    hecc_status_e      status_d;
    hecc_result_t      res_d;
    hecc_result_t      res_q;
    logic              valid_q;

    hecc_syndrome #(
        .CODE_W (CODE_W),
        .LOC_W  (LOC_W),
        .CNT_W  (CNT_W)
    ) u_syn (
        .calc_i   (calc_code_i),
        .stored_i (stored_code_i),
        .odd_o    (odd_bits),
        .weight_o (weight),
        .zero_o   (syn_zero)
    );

    hecc_classify #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_cls (
        .weight_i (weight),
        .zero_i   (syn_zero),
        .status_o (status_d)
    );

    hecc_locate #(
        .LOC_W  (LOC_W),
        .BIT_W  (BIT_W),
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_loc (
        .odd_i       (odd_bits),
        .fix_i       (status_d == HS_FIXED),
        .byte_addr_o (res_d.byte_addr),
        .bit_pos_o   (res_d.bit_pos),
        .mask_o      (res_d.flip_mask)
    );

    assign res_d.status = status_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= HECC_RESULT_RST;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start_i;
            if (start_i) begin
                res_q <= res_d;
            end
        end
    end

    assign valid_o     = valid_q;
    assign status_o    = res_q.status;
    assign byte_addr_o = res_q.byte_addr;
    assign bit_pos_o   = res_q.bit_pos;
    assign flip_mask_o = res_q.flip_mask;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);
    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);
    // R3
    clean_status_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && syn_zero) |=> (status_o == 2'b00));
    // R4
    fixed_status_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && weight == FIX_WEIGHT) |=> (status_o == 2'b01));
    // R6
    fail_status_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && weight >= FAIL_WEIGHT) |=> (status_o == 2'b11));
    // R9
    mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o == 2'b01) |-> ($countones(flip_mask_o) == 1 && flip_mask_o[bit_pos_o]));
    // R9
    loc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o != 2'b01) |-> (flip_mask_o == '0 && byte_addr_o == '0 && bit_pos_o == '0));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(status_o) && $stable(byte_addr_o) && $stable(flip_mask_o)));

endmodule

// File: tb/tb_hecc_sector_check.sv
`timescale 1ns/1ps
module tb_hecc_sector_check;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] calc_code_i = '0;
    logic [23:0] stored_code_i = '0;
    logic        valid_o;
    logic [1:0]  status_o;
    logic [8:0]  byte_addr_o;
    logic [2:0]  bit_pos_o;
    logic [7:0]  flip_mask_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference state
    bit          m_valid = 0;
    bit          m_fresh = 0;
    int          m_status = 0;
    int          m_addr = 0;
    int          m_bit = 0;
    int          m_mask = 0;

    always #2.5 clk = ~clk;

    hecc_sector_check dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .calc_code_i   (calc_code_i),
        .stored_code_i (stored_code_i),
        .valid_o       (valid_o),
        .status_o      (status_o),
        .byte_addr_o   (byte_addr_o),
        .bit_pos_o     (bit_pos_o),
        .flip_mask_o   (flip_mask_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural model, updated on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_valid = 0; m_fresh = 0;
            m_status = 0; m_addr = 0; m_bit = 0; m_mask = 0;
        end else begin
            m_valid = start_i;
            m_fresh = start_i;
            if (start_i) begin
                logic [23:0] s;
                int w;
                s = calc_code_i ^ stored_code_i;
                w = 0;
                for (int i = 0; i < 24; i++) if (s[i]) w++;
                if (w == 0) m_status = 0;
                else if (w == 12) m_status = 1;
                else if (w >= 23) m_status = 3;
                else m_status = 2;
                m_addr = 0; m_bit = 0; m_mask = 0;
                if (m_status == 1) begin
                    m_bit = s[1] + 2 * s[3] + 4 * s[5];
                    for (int a = 0; a < 9; a++) if (s[7 + 2 * a]) m_addr += (1 << a);
                    m_mask = 1 << m_bit;
                end
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            string sreq;
            check("R2", "valid", int'(valid_o), int'(m_valid));
            if (!m_fresh) sreq = "R10";
            else case (m_status)
                0: sreq = "R3";
                1: sreq = "R4";
                2: sreq = "R5";
                default: sreq = "R6";
            endcase
            check(sreq, "status", int'(status_o), m_status);
            check(m_fresh ? "R7" : "R10", "bit_pos", int'(bit_pos_o), m_bit);
            check(m_fresh ? "R8" : "R10", "byte_addr", int'(byte_addr_o), m_addr);
            check(m_fresh ? "R9" : "R10", "flip_mask", int'(flip_mask_o), m_mask);
        end
    end

    function automatic logic [23:0] single_err(input int addr, input int bpos);
        logic [11:0] p;
        logic [23:0] s;
        p = {addr[8:0], bpos[2:0]};
        for (int k = 0; k < 12; k++) begin
            s[2*k+1] = p[k];
            s[2*k]   = ~p[k];
        end
        return s;
    endfunction

    function automatic logic [23:0] weight_pat(input int n);
        logic [23:0] s;
        s = '0;
        for (int i = 0; i < n; i++) s[i] = 1'b1;
        return s;
    endfunction

    task automatic apply(input logic [23:0] base, input logic [23:0] syn);
        @(negedge clk);
        start_i = 1'b1;
        stored_code_i = base;
        calc_code_i = base ^ syn;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 1; i < n; i++) begin
            calc_code_i = 24'($urandom);
            stored_code_i = 24'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while held in reset
        check("R1", "valid in reset", int'(valid_o), 0);
        check("R1", "status in reset", int'(status_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mask after reset", int'(flip_mask_o), 0);
        check("R1", "addr after reset", int'(byte_addr_o), 0);

        // R3: clean sectors
        apply(24'h5A3C91, 24'h0); idle(2);
        apply(24'hFFFFFF, 24'h0); idle(2);
        // R4, R7, R8, R9: true single-bit errors at corners and random spots
        apply(24'h123456, single_err(0, 0)); idle(2);
        apply(24'h0F0F0F, single_err(511, 7)); idle(2);
        apply(24'hA5A5A5, single_err(256, 4)); idle(2);
        for (int t = 0; t < 20; t++) begin
            apply(24'($urandom), single_err(int'($urandom_range(0, 511)), int'($urandom_range(0, 7))));
            idle(1 + (t % 3));
        end
        // R4: any 12-one pattern counts as correctable
        apply(24'h000000, weight_pat(12)); idle(2);
        apply(24'h3C3C3C, 24'hFFF000); idle(2);
        // R5: uncorrectable weights around 12 and below 23
        apply(24'h111111, weight_pat(1)); idle(2);
        apply(24'h222222, 24'h800000); idle(2);
        apply(24'h333333, weight_pat(2)); idle(2);
        apply(24'h444444, weight_pat(11)); idle(2);
        apply(24'h555555, weight_pat(13)); idle(2);
        apply(24'h666666, weight_pat(22)); idle(2);
        // R6: code failure
        apply(24'h777777, weight_pat(23)); idle(2);
        apply(24'h888888, weight_pat(24)); idle(2);
        // R2: back-to-back starts
        apply(24'h010203, single_err(77, 3));
        apply(24'h040506, weight_pat(5));
        apply(24'h070809, 24'h0);
        apply(24'h0A0B0C, single_err(300, 6));
        // R10: long idle with changing inputs
        idle(30);
        for (int t = 0; t < 40; t++) begin
            apply(24'($urandom), 24'($urandom));
            idle(1 + (t % 4));
        end
        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule